// File: doc/BRIEF.md
# T1 Robbed-Bit Signalling Inserter

This block sits in the transmit path of a T1 framer. It receives one 8-bit channel byte per valid cycle, along with the 1-based frame number inside the current multiframe and the channel index (0 to 23). In every sixth frame it replaces the least significant bit of each channel byte with one bit of that channel's signalling nibble. In extended-superframe operation the multiframe is 24 frames long and frames 6, 12, 18 and 24 carry the A, B, C and D bits. In superframe operation it is 12 frames long and only frames 6 and 12 carry bits (A and B). All other bytes pass through unchanged, with one register of latency.

Two tables supply each channel's nibble: a processor-written table and a table recovered from the serial control stream. A per-channel select bit chooses between them. All 24 nibbles are captured together on the first byte of each multiframe, so the A-to-D bits of one multiframe always come from one consistent value. A robbed-bit disable input, when high, turns insertion off, and every byte then passes through untouched.

Top module: `rbs_inserter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid_o` is 0 and `data_o` is 0.
- R2: `out_valid_o` equals `valid_i` delayed by one clock, and `data_o` carries the byte presented on the previous valid cycle.
- R3: Bits 7..1 of every output byte equal bits 7..1 of the corresponding input byte.
- R4: A byte whose frame number is not a multiple of 6 leaves the block with all 8 bits unchanged.
- R5: With `esf_i` = 1, bit 0 of each channel in frames 6, 12, 18 and 24 is replaced by nibble bit 3 (A), bit 2 (B), bit 1 (C) and bit 0 (D) respectively.
- R6: With `esf_i` = 0, frame 6 carries nibble bit 3 (A) and frame 12 carries nibble bit 2 (B). Frame numbers above 12 pass through unchanged.
- R7: While `rob_dis_i` is 1, every byte passes through unchanged in every frame.
- R8: For channel c, the nibble is `proc_tbl_i[4c+3:4c]` when `proc_sel_i[c]` is 1, and otherwise `ser_tbl_i[4c+3:4c]`.
- R9: All nibbles are captured on the valid byte with frame 1 and channel 0. Changes to the tables or selects after that byte have no effect until the next such byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | A channel byte is presented this cycle |
| frame_i | input | 5 | Frame number within the multiframe, 1-based |
| chan_i | input | 5 | Channel index, 0..23 |
| data_i | input | 8 | Channel byte in |
| esf_i | input | 1 | 1: 24-frame multiframe with ABCD; 0: 12-frame with AB |
| rob_dis_i | input | 1 | 1 disables bit robbing |
| proc_sel_i | input | 24 | Per-channel source select, 1 = processor table |
| proc_tbl_i | input | 96 | Processor nibble table, channel c at bits 4c+3..4c |
| ser_tbl_i | input | 96 | Serial-stream nibble table, same layout |
| data_o | output | 8 | Channel byte out |
| out_valid_o | output | 1 | `data_o` holds a new byte |

## Verification
The bench sweeps every channel of every frame through two multiframes in each mode, plus one multiframe with robbing disabled. Each output byte is compared with a value the bench computes itself. The bench rewrites both tables and the selects in frame 3 of each multiframe. A design that samples nibbles continuously would then emit a mix of old and new bits within one multiframe. A swapped A/B/C/D bit order, a missing superframe truncation at frame 12, or an inverted source select each shows up as wrong bit-0 values in frames 6 to 24. Checks on idle cycles and on bits 7..1 catch a design that drifts in latency or corrupts more than the robbed bit.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  // True when this 1-based frame carries a signalling bit.
  function automatic bit is_rob_frame(input int frame, input int mf_len, input int period);
    return (frame >= period) && (frame <= mf_len) && ((frame % period) == 0);
  endfunction

  // Position of the carried bit inside the nibble (A is the top bit).
  function automatic int nib_bit_of(input int frame, input int period, input int nib_w);
    return nib_w - (frame / period);
  endfunction
endpackage

// File: rtl/rbs_frame_decode.sv
module rbs_frame_decode #(
  parameter int FR_W       = 5,
  parameter int ROB_PERIOD = 6,
  parameter int ESF_LEN    = 24,
  parameter int D4_LEN     = 12,
  parameter int NIB_W      = 4,
  localparam int BI_W      = (NIB_W > 1) ? $clog2(NIB_W) : 1
) (
  input  logic [FR_W-1:0] frame_i,
  input  logic            esf_i,
  output logic            rob_o,
  output logic [BI_W-1:0] bit_idx_o
);
  import rbs_pkg::*;

  int mf_len;
  int bpos;

  always_comb begin
    mf_len    = esf_i ? ESF_LEN : D4_LEN;
    rob_o     = is_rob_frame(int'(frame_i), mf_len, ROB_PERIOD);
    bpos      = nib_bit_of(int'(frame_i), ROB_PERIOD, NIB_W);
    bit_idx_o = '0;
    if (rob_o && bpos >= 0) bit_idx_o = BI_W'(bpos);
  end
endmodule

// File: rtl/rbs_nibble_store.sv
module rbs_nibble_store #(
  parameter int N_CH  = 24,
  parameter int NIB_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       capture_i,
  input  logic [N_CH-1:0]            proc_sel_i,
  input  logic [N_CH*NIB_W-1:0]      proc_tbl_i,
  input  logic [N_CH*NIB_W-1:0]      ser_tbl_i,
  output logic [N_CH-1:0][NIB_W-1:0] held_o
);
  logic [N_CH-1:0][NIB_W-1:0] pick;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign pick[c] = proc_sel_i[c] ? proc_tbl_i[c*NIB_W +: NIB_W]
                                   : ser_tbl_i[c*NIB_W +: NIB_W];
    always_ff @(posedge clk) begin
      if (!rst_n)         held_o[c] <= '0;
      else if (capture_i) held_o[c] <= pick[c];
    end
  end

  // R9
  hold_between_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> $stable(held_o));
endmodule

// File: rtl/rbs_byte_merge.sv
module rbs_byte_merge #(
  parameter int N_CH   = 24,
  parameter int NIB_W  = 4,
  parameter int CH_W   = 5,
  parameter int BYTE_W = 8,
  localparam int BI_W  = (NIB_W > 1) ? $clog2(NIB_W) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       valid_i,
  input  logic [BYTE_W-1:0]          data_i,
  input  logic [CH_W-1:0]            chan_i,
  input  logic                       rob_i,
  input  logic [BI_W-1:0]            bit_idx_i,
  input  logic [N_CH-1:0][NIB_W-1:0] held_i,
  output logic [BYTE_W-1:0]          data_o,
  output logic                       valid_o
);
  logic [NIB_W-1:0]  cur_nib;
  logic              sig_bit;
  logic [BYTE_W-1:0] merged;

  always_comb begin
    cur_nib = '0;
    for (int c = 0; c < N_CH; c++)
      if (int'(chan_i) == c) cur_nib = held_i[c];
    sig_bit = cur_nib[bit_idx_i];
    merged  = rob_i ? {data_i[BYTE_W-1:1], sig_bit} : data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= merged;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);
  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !valid_o);
  // R3
  upper_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> data_o[BYTE_W-1:1] == $past(data_i[BYTE_W-1:1]));
endmodule

// File: rtl/rbs_inserter.sv
module rbs_inserter #(
  parameter int N_CH       = 24,
  parameter int NIB_W      = 4,
  parameter int BYTE_W     = 8,
  parameter int ROB_PERIOD = 6,
  parameter int ESF_LEN    = 24,
  parameter int D4_LEN     = 12,
  localparam int FR_W      = $clog2(ESF_LEN + 1),
  localparam int CH_W      = $clog2(N_CH),
  localparam int BI_W      = (NIB_W > 1) ? $clog2(NIB_W) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  valid_i,
  input  logic [FR_W-1:0]       frame_i,
  input  logic [CH_W-1:0]       chan_i,
  input  logic [BYTE_W-1:0]     data_i,
  input  logic                  esf_i,
  input  logic                  rob_dis_i,
  input  logic [N_CH-1:0]       proc_sel_i,
  input  logic [N_CH*NIB_W-1:0] proc_tbl_i,
  input  logic [N_CH*NIB_W-1:0] ser_tbl_i,
  output logic [BYTE_W-1:0]     data_o,
  output logic                  out_valid_o
);
  logic                       rob_hit;
  logic [BI_W-1:0]            bit_idx;
  logic                       mf_start;
  logic                       rob_active;
  logic [N_CH-1:0][NIB_W-1:0] held;

  assign mf_start   = valid_i && (frame_i == FR_W'(1)) && (chan_i == '0);
  assign rob_active = valid_i && !rob_dis_i && rob_hit && (int'(chan_i) < N_CH);

  rbs_frame_decode #(
    .FR_W(FR_W), .ROB_PERIOD(ROB_PERIOD), .ESF_LEN(ESF_LEN),
    .D4_LEN(D4_LEN), .NIB_W(NIB_W)
  ) decode_i (
    .frame_i(frame_i), .esf_i(esf_i), .rob_o(rob_hit), .bit_idx_o(bit_idx)
  );

  rbs_nibble_store #(.N_CH(N_CH), .NIB_W(NIB_W)) store_i (
    .clk(clk), .rst_n(rst_n), .capture_i(mf_start),
    .proc_sel_i(proc_sel_i), .proc_tbl_i(proc_tbl_i), .ser_tbl_i(ser_tbl_i),
    .held_o(held)
  );

  rbs_byte_merge #(
    .N_CH(N_CH), .NIB_W(NIB_W), .CH_W(CH_W), .BYTE_W(BYTE_W)
  ) merge_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .data_i(data_i),
    .chan_i(chan_i), .rob_i(rob_active), .bit_idx_i(bit_idx),
    .held_i(held), .data_o(data_o), .valid_o(out_valid_o)
  );

  // R4
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !rob_active) |=> data_o == $past(data_i));
  // R7
  rob_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && rob_dis_i) |=> data_o == $past(data_i));
  // R4
  rob_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rob_active |-> (int'(frame_i) % ROB_PERIOD) == 0);
  // R6
  d4_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rob_active && !esf_i) |-> int'(frame_i) <= D4_LEN);
endmodule

// File: tb/rbs_inserter_tb_top.sv
module rbs_inserter_tb_top;
  localparam int NCH = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0;
  logic [4:0]    frame_i = '0;
  logic [4:0]    chan_i = '0;
  logic [7:0]    data_i = '0;
  logic          esf_i = 1'b1;
  logic          rob_dis_i = 1'b0;
  logic [23:0]   proc_sel_i = '0;
  logic [95:0]   proc_tbl_i = '0;
  logic [95:0]   ser_tbl_i = '0;
  logic [7:0]    data_o;
  logic          out_valid_o;

  int tests = 0;
  int fails = 0;
  logic [3:0] exp_nib [NCH];

  always #4 clk = ~clk;

  rbs_inserter dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .frame_i(frame_i),
    .chan_i(chan_i), .data_i(data_i), .esf_i(esf_i), .rob_dis_i(rob_dis_i),
    .proc_sel_i(proc_sel_i), .proc_tbl_i(proc_tbl_i), .ser_tbl_i(ser_tbl_i),
    .data_o(data_o), .out_valid_o(out_valid_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_tables(input int seed);
    for (int c = 0; c < NCH; c++) begin
      proc_tbl_i[c*4 +: 4] = 4'((seed + c * 7) & 15);
      ser_tbl_i[c*4 +: 4]  = 4'((seed * 3 + c * 5 + 9) & 15);
      proc_sel_i[c]        = ((c + seed) % 3) == 0;
    end
  endtask

  // Expected byte, computed from R4..R8 directly.
  function automatic logic [7:0] expect_byte(input int f, input int c, input logic [7:0] d,
                                             input bit esf, input bit dis);
    int slot;
    int len;
    len = esf ? 24 : 12;
    if (dis || f > len || (f % 6) != 0) return d;
    slot = f / 6;                       // 1 -> A (bit3), 2 -> B, 3 -> C, 4 -> D
    return {d[7:1], exp_nib[c][4 - slot]};
  endfunction

  task automatic run_mf(input bit esf, input bit dis, input int mf, input string req);
    int len;
    len = esf ? 24 : 12;
    for (int f = 1; f <= len; f++) begin
      for (int c = 0; c < NCH; c++) begin
        logic [7:0] d;
        logic [7:0] e;
        d = 8'(f * 37 + c * 11 + mf * 5);
        @(negedge clk);
        if (f == 1 && c == 0) begin
          load_tables(mf * 13 + 1);
          for (int k = 0; k < NCH; k++)
            exp_nib[k] = proc_sel_i[k] ? proc_tbl_i[k*4 +: 4] : ser_tbl_i[k*4 +: 4];
        end
        if (f == 3 && c == 0) load_tables(mf * 13 + 100);  // R9: late change ignored
        valid_i = 1'b1; frame_i = 5'(f); chan_i = 5'(c); data_i = d;
        esf_i = esf; rob_dis_i = dis;
        e = expect_byte(f, c, d, esf, dis);
        @(posedge clk); #1;
        check("R2 valid", {7'd0, out_valid_o}, 8'd1);
        check(req, data_o, e);
        check("R3 upper bits", {1'b0, data_o[7:1]}, {1'b0, d[7:1]});
      end
      @(negedge clk);
      valid_i = 1'b0;
      @(posedge clk); #1;
      check("R2 idle", {7'd0, out_valid_o}, 8'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    check("R1 reset valid", {7'd0, out_valid_o}, 8'd0);
    check("R1 reset data", data_o, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", {7'd0, out_valid_o}, 8'd0);
    for (int m = 0; m < 2; m++) run_mf(1'b1, 1'b0, m, "R5 R8 R9 esf");
    for (int m = 2; m < 4; m++) run_mf(1'b0, 1'b0, m, "R6 R8 R9 d4");
    run_mf(1'b1, 1'b1, 4, "R7 disabled");
    run_mf(1'b1, 1'b0, 5, "R4 R5 esf again");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule